// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This unit sits next to a processor core and decides which interrupt vector it should take next. Sources post requests as an 8-bit vector with a trigger-mode flag. The unit records each request in a 256-bit request bitmap and notes its trigger mode in a 256-bit trigger bitmap. It raises a single pending line toward the core when the best waiting vector outranks the current processor priority.

The core takes an interrupt with a one-cycle acknowledge strobe and reads the answer in that same cycle. The answer is the vector to service, the spurious vector when task priority masks the best request, or "none". Taking a real vector moves it from the request bitmap into the in-service bitmap. An end-of-interrupt strobe retires the highest in-service vector.

Software controls the unit through two registers. An 8-bit task priority register sets a floor for acceptance. A 9-bit spurious register holds the spurious vector in bits 7:0 and a global enable in bit 8. Read ports show the processor priority, both registers, and any selected 32-bit slice of the three bitmaps.

Top module: `irq_prio_ack`

## Requirements
- R1: On a cycle with `req_valid` high, the next state has bit `req_vec` set in the request bitmap. The trigger bitmap bit takes the value of `req_level` (1 for level-triggered, 0 for edge-triggered).
- R2: While bit 8 of the spurious register is 0, `pend` is low. An acknowledge in that state returns `ack_none`=1 with `ack_vec`=0 and changes no bitmap.
- R3: `ppr_out` equals the task priority in two cases: the in-service bitmap is empty, or bits 7:4 of the task priority are at least bits 7:4 of the highest in-service vector. Otherwise `ppr_out` is that vector with bits 3:0 zeroed.
- R4: An acknowledge with an empty request bitmap returns `ack_none`=1 and `ack_vec`=0.
- R5: `pend` is high exactly when the unit is enabled and bits 7:4 of the highest requested vector are strictly greater than bits 7:4 of `ppr_out`.
- R6: An acknowledge may find a nonzero task priority with the highest requested vector less than or equal to it. Then `ack_vec` is bits 7:0 of the spurious register, `ack_none` is 0, and no bitmap changes.
- R7: Any other acknowledge returns the highest requested vector with `ack_none`=0. On the next clock that vector's request bit is clear and its in-service bit is set.
- R8: `eoi` clears the highest set in-service bit on the next clock. With an empty in-service bitmap it has no effect.
- R9: A write through `svr_we` stores bits 8:0 of `svr_wdata` and drops the upper bits.
- R10: After reset the task priority is 0, the spurious register reads 0x0FF, and all three bitmaps are empty.
- R11: A task priority write takes effect at the next clock. From then on `pend` and `ppr_out` follow the new value, and `pend` falls if no request still qualifies.
- R12: When several events share a cycle, they apply in a fixed order. End-of-interrupt acts first, on the old in-service state. The acknowledge transfer comes next, and the incoming request last. So a request for the vector being acknowledged leaves its request bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Accept a request this cycle |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| svr_we | input | 1 | Spurious register write strobe |
| svr_wdata | input | 16 | Spurious register write value (bits 8:0 kept) |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| slice_sel | input | 3 | Selects bits [32*sel+31 : 32*sel] of each bitmap |
| pend | output | 1 | Interrupt pending toward the core |
| ack_vec | output | 8 | Vector returned for an acknowledge |
| ack_none | output | 1 | Acknowledge has nothing to return |
| ppr_out | output | 8 | Processor priority |
| tpr_out | output | 8 | Task priority register |
| svr_rd | output | 9 | Spurious register |
| irr_slice | output | 32 | Selected slice of the request bitmap |
| isr_slice | output | 32 | Selected slice of the in-service bitmap |
| tmr_slice | output | 32 | Selected slice of the trigger bitmap |

## Verification
The assertions assume two things about the inputs. Every control input holds a known value at each rising edge, and reset is asserted from time zero. The register-write assertions also rely on nothing but a write touching those registers. The bench drives all inputs on the falling edge with defined values and holds reset low for several cycles before releasing it. It then sweeps random vectors over the full 0 to 255 range, with task priorities biased so that both spurious and real acknowledges occur. Directed steps first cover the disabled state, masking by task priority, and retirement order.

// File: rtl/irq_prio_ack.sv
module irq_prio_ack #(
  parameter int NVEC    = 256,
  parameter int SLICE_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [$clog2(NVEC)-1:0]       req_vec,
  input  logic                          req_level,
  input  logic                          tpr_we,
  input  logic [$clog2(NVEC)-1:0]       tpr_wdata,
  input  logic                          svr_we,
  input  logic [2*$clog2(NVEC)-1:0]     svr_wdata,
  input  logic                          ack,
  input  logic                          eoi,
  input  logic [$clog2(NVEC/SLICE_W)-1:0] slice_sel,
  output logic                          pend,
  output logic [$clog2(NVEC)-1:0]       ack_vec,
  output logic                          ack_none,
  output logic [$clog2(NVEC)-1:0]       ppr_out,
  output logic [$clog2(NVEC)-1:0]       tpr_out,
  output logic [$clog2(NVEC):0]         svr_rd,
  output logic [SLICE_W-1:0]            irr_slice,
  output logic [SLICE_W-1:0]            isr_slice,
  output logic [SLICE_W-1:0]            tmr_slice
);
  localparam int VW = $clog2(NVEC);

  logic [NVEC-1:0] irr, isr, tmr;
  logic [NVEC-1:0] irr_n, isr_n, tmr_n;
  logic [VW-1:0]   tpr;
  logic [VW:0]     svr;
  logic [VW:0]     irr_top, isr_top;
  logic            enabled, spur, take;

  function automatic logic [VW:0] top_of(input logic [NVEC-1:0] m);
    logic [VW:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (m[i]) r = {1'b1, VW'(i)};
    return r;
  endfunction

  assign irr_top = top_of(irr);
  assign isr_top = top_of(isr);
  assign enabled = svr[VW];

  assign ppr_out = (!isr_top[VW] || tpr[VW-1:4] >= isr_top[VW-1:4]) ? tpr
                   : {isr_top[VW-1:4], 4'b0000};

  assign pend = enabled && irr_top[VW] && (irr_top[VW-1:4] > ppr_out[VW-1:4]);

  assign ack_none = !enabled || !irr_top[VW];
  assign spur     = (tpr != '0) && (irr_top[VW-1:0] <= tpr);
  assign ack_vec  = ack_none ? '0 : (spur ? svr[VW-1:0] : irr_top[VW-1:0]);
  assign take     = ack && !ack_none && !spur;

  always_comb begin
    irr_n = irr;
    isr_n = isr;
    tmr_n = tmr;
    if (eoi && isr_top[VW]) isr_n[isr_top[VW-1:0]] = 1'b0;
    if (take) begin
      irr_n[irr_top[VW-1:0]] = 1'b0;
      isr_n[irr_top[VW-1:0]] = 1'b1;
    end
    if (req_valid) begin
      irr_n[req_vec] = 1'b1;
      tmr_n[req_vec] = req_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
      tpr <= '0;
      svr <= {1'b0, {VW{1'b1}}};
    end else begin
      irr <= irr_n;
      isr <= isr_n;
      tmr <= tmr_n;
      if (tpr_we) tpr <= tpr_wdata;
      if (svr_we) svr <= svr_wdata[VW:0];
    end
  end

  assign tpr_out   = tpr;
  assign svr_rd    = svr;
  assign irr_slice = irr[slice_sel*SLICE_W +: SLICE_W];
  assign isr_slice = isr[slice_sel*SLICE_W +: SLICE_W];
  assign tmr_slice = tmr[slice_sel*SLICE_W +: SLICE_W];
endmodule

// File: rtl/irq_prio_ack_chk.sv
module irq_prio_ack_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          ack_none,
  input logic [VW-1:0] ack_vec,
  input logic          pend,
  input logic [VW-1:0] ppr_out,
  input logic [VW-1:0] tpr_out,
  input logic [VW:0]   svr_rd,
  input logic          svr_we,
  input logic [2*VW-1:0] svr_wdata,
  input logic          tpr_we,
  input logic [VW-1:0] tpr_wdata
);
  // R2
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> svr_rd[VW]);

  // R2
  ack_disabled_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !svr_rd[VW]) |-> (ack_none && ack_vec == '0));

  // R3
  ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_out[VW-1:4] >= tpr_out[VW-1:4]);

  // R6
  masked_gives_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_none && tpr_out != '0 && ack_vec <= tpr_out) |-> ack_vec == svr_rd[VW-1:0]);

  // R9
  svr_write_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svr_we |=> svr_rd == $past(svr_wdata[VW:0]));

  // R11
  tpr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we |=> tpr_out == $past(tpr_wdata));
endmodule

bind irq_prio_ack irq_prio_ack_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .ack_none(ack_none), .ack_vec(ack_vec),
  .pend(pend), .ppr_out(ppr_out), .tpr_out(tpr_out), .svr_rd(svr_rd),
  .svr_we(svr_we), .svr_wdata(svr_wdata), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata)
);

// File: tb/irq_prio_ack_bench.sv
module irq_prio_ack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vec = '0;
  logic        req_level = 1'b0;
  logic        tpr_we = 1'b0;
  logic [7:0]  tpr_wdata = '0;
  logic        svr_we = 1'b0;
  logic [15:0] svr_wdata = '0;
  logic        ack = 1'b0;
  logic        eoi = 1'b0;
  logic [2:0]  slice_sel = '0;
  logic        pend, ack_none;
  logic [7:0]  ack_vec, ppr_out, tpr_out;
  logic [8:0]  svr_rd;
  logic [31:0] irr_slice, isr_slice, tmr_slice;

  irq_prio_ack u_irq_prio_ack (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_level(req_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .svr_we(svr_we), .svr_wdata(svr_wdata), .ack(ack), .eoi(eoi),
    .slice_sel(slice_sel), .pend(pend), .ack_vec(ack_vec), .ack_none(ack_none),
    .ppr_out(ppr_out), .tpr_out(tpr_out), .svr_rd(svr_rd),
    .irr_slice(irr_slice), .isr_slice(isr_slice), .tmr_slice(tmr_slice)
  );

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  bit m_irr[256], m_isr[256], m_tmr[256];
  int m_tpr, m_svr;

  function automatic int highest(input bit m[256]);
    int r = -1;
    for (int i = 0; i < 256; i++) if (m[i]) r = i;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_ppr();
    int it = highest(m_isr);
    if (it < 0 || (m_tpr >> 4) >= (it >> 4)) return m_tpr;
    return it & 8'hF0;
  endfunction

  // Compare all outputs against the model, and return the acknowledge decision
  task automatic compare(output int take_vec);
    int ir = highest(m_irr);
    int pp = exp_ppr();
    bit en = m_svr[8];
    bit e_pend = en && ir >= 0 && (ir >> 4) > (pp >> 4);
    int e_vec; bit e_none;
    logic [31:0] s_irr, s_isr, s_tmr;
    take_vec = -1;
    chk(ppr_out == pp[7:0], "R3 ppr", ppr_out, pp);
    chk(pend == e_pend, en ? "R5 pend" : "R2 pend", pend, e_pend);
    chk(tpr_out == m_tpr[7:0], "R11 tpr", tpr_out, m_tpr);
    chk(svr_rd == m_svr[8:0], "R9 svr", svr_rd, m_svr);
    for (int b = 0; b < 32; b++) begin
      s_irr[b] = m_irr[slice_sel*32 + b];
      s_isr[b] = m_isr[slice_sel*32 + b];
      s_tmr[b] = m_tmr[slice_sel*32 + b];
    end
    chk(irr_slice == s_irr, "R1 irr", irr_slice, s_irr);
    chk(isr_slice == s_isr, "R7 isr", isr_slice, s_isr);
    chk(tmr_slice == s_tmr, "R1 tmr", tmr_slice, s_tmr);
    if (ack) begin
      if (!en || ir < 0) begin
        e_none = 1; e_vec = 0;
      end else if (m_tpr != 0 && ir <= m_tpr) begin
        e_none = 0; e_vec = m_svr & 8'hFF;
      end else begin
        e_none = 0; e_vec = ir; take_vec = ir;
      end
      chk(ack_none == e_none, !en ? "R2 ack_none" : "R4 ack_none", ack_none, e_none);
      chk(ack_vec == e_vec[7:0], take_vec < 0 ? "R6 ack_vec" : "R7 ack_vec", ack_vec, e_vec);
    end
  endtask

  task automatic step();
    int tk;
    int it;
    #1 compare(tk);
    @(posedge clk);
    it = highest(m_isr);
    // R12 order: end-of-interrupt, acknowledge transfer, request
    if (eoi && it >= 0) m_isr[it] = 0;
    if (tk >= 0) begin m_irr[tk] = 0; m_isr[tk] = 1; end
    if (req_valid) begin m_irr[req_vec] = 1; m_tmr[req_vec] = req_level; end
    if (tpr_we) m_tpr = tpr_wdata;
    if (svr_we) m_svr = svr_wdata & 16'h1FF;
    @(negedge clk);
    slice_sel = slice_sel + 3'd1;
  endtask

  task automatic idle();
    req_valid = 0; tpr_we = 0; svr_we = 0; ack = 0; eoi = 0;
  endtask

  task automatic post(input int v, input bit lvl);
    idle(); req_valid = 1; req_vec = v[7:0]; req_level = lvl; step(); idle();
  endtask

  task automatic do_ack();
    idle(); ack = 1; step(); idle();
  endtask

  task automatic do_eoi();
    idle(); eoi = 1; step(); idle();
  endtask

  task automatic wr_tpr(input int v);
    idle(); tpr_we = 1; tpr_wdata = v[7:0]; step(); idle();
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m_irr[i] = 0; m_isr[i] = 0; m_tmr[i] = 0; end
    m_tpr = 0; m_svr = 'h0FF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    #1;
    chk(tpr_out == 8'h00, "R10 tpr reset", tpr_out, 0);
    chk(svr_rd == 9'h0FF, "R10 svr reset", svr_rd, 'hFF);
    chk(pend == 1'b0, "R10 pend reset", pend, 0);
    step();
    // R2 disabled: request held, no pend, acknowledge returns none
    post('h45, 1);
    do_ack();
    chk(irr_slice != 0 || slice_sel != 3'd2, "R2 irr untouched", irr_slice, 0);
    // R9 enable with truncation of upper bits
    idle(); svr_we = 1; svr_wdata = 16'hA3F5; step(); idle();
    chk(svr_rd == 9'h1F5, "R9 svr trunc", svr_rd, 'h1F5);
    step();
    chk(pend == 1'b1, "R5 pend 0x45", pend, 1);
    do_ack();
    chk(ppr_out == 8'h40, "R3 ppr from isr", ppr_out, 'h40);
    chk(pend == 1'b0, "R7 pend after ack", pend, 0);
    post('h42, 1);
    chk(pend == 1'b0, "R5 same class", pend, 0);
    post('h81, 0);
    chk(pend == 1'b1, "R5 higher class", pend, 1);
    post('h42, 0); // R1 level then edge clears trigger bit
    wr_tpr('h90);
    chk(pend == 1'b0, "R11 pend dropped", pend, 0);
    do_ack(); // R6 spurious 0xF5
    wr_tpr('h00);
    do_ack();
    chk(ppr_out == 8'h80, "R7 ppr 0x81", ppr_out, 'h80);
    do_eoi();
    chk(ppr_out == 8'h40, "R8 eoi highest", ppr_out, 'h40);
    do_eoi();
    do_eoi(); // R8 empty in-service
    // R12 acknowledge and request same vector
    idle(); ack = 1; req_valid = 1; req_vec = 8'h42; req_level = 1; step(); idle();
    do_ack(); do_ack(); do_ack();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      idle();
      req_valid = ($urandom_range(0, 2) == 0);
      req_vec = 8'($urandom_range(0, 255));
      req_level = 1'($urandom_range(0, 1));
      ack = ($urandom_range(0, 3) == 0);
      eoi = ($urandom_range(0, 4) == 0);
      if (r < 6) begin tpr_we = 1; tpr_wdata = (r < 2) ? 8'h00 : 8'($urandom_range(0, 255)); end
      if (r == 99) begin svr_we = 1; svr_wdata = 16'($urandom_range(0, 65535)); end
      if (r == 98) begin svr_we = 1; svr_wdata = 16'h01C3; end
      step();
    end
    idle(); step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule